// File: doc/BRIEF.md
# Register Alias Table with Architected Value File

This block sits at the dispatch stage of a dynamically scheduled core. For every architectural register it stores a producer tag next to a committed value. A tag of zero means the register file already holds the newest value. A nonzero tag names the reservation station that will produce that value. Two source lookups and one destination rename are served each cycle. A single result-bus port returns completed results to the block.

At dispatch each source lookup returns one of two things: a ready value (from the file, or forwarded from a result broadcast in the same cycle) or the pending tag. The instruction's destination is renamed to its new tag at once, even when an older producer of that register is still outstanding. When a result tag is broadcast, every register still mapped to that tag takes the value and goes back to tag zero. A register renamed again since that tag was recorded keeps its newer mapping. Older consumers already hold their own copies of the values they need.

Top module: `register_alias_table`

## Requirements
- R1: After reset every register has tag 0 and value 0, so both lookups report ready with value 0 for any register.
- R2: A source whose register holds tag 0 (and no result is forwarded) reports ready=1, tag 0, and the register-file value.
- R3: A source whose register holds a nonzero tag that is not being broadcast reports ready=0, that tag, and value 0.
- R4: A rename writes the new tag into the destination register, visible from the next cycle, even if the register already holds a different nonzero tag. Rename tags are always nonzero.
- R5: A broadcast of nonzero tag T with value V turns every register holding T into tag 0 with value V, visible from the next cycle.
- R6: A broadcast whose tag differs from a register's stored tag leaves that register's tag and value unchanged.
- R7: A source whose stored tag equals the nonzero tag broadcast in the same cycle reports ready=1, tag 0, and the broadcast value in that cycle.
- R8: When a rename and a matching broadcast hit the same register in the same cycle, the register ends with the rename tag.
- R9: A broadcast with the valid input low, or with tag 0, changes no register.
- R10: Source lookups see the mapping held before a same-cycle rename, so an instruction that reads and writes one register reads the old mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rename_en | input | 1 | Destination rename strobe |
| rename_reg | input | 3 | Destination architectural register |
| rename_tag | input | 3 | New producer tag (nonzero) |
| bcast_valid | input | 1 | Result bus carries a result |
| bcast_tag | input | 3 | Tag of the broadcast result |
| bcast_value | input | 16 | Value of the broadcast result |
| src_a_reg | input | 3 | First source register |
| src_b_reg | input | 3 | Second source register |
| src_a_ready | output | 1 | First source has a value |
| src_a_tag | output | 3 | First source pending tag (0 when ready) |
| src_a_value | output | 16 | First source value (0 when pending) |
| src_b_ready | output | 1 | Second source has a value |
| src_b_tag | output | 3 | Second source pending tag (0 when ready) |
| src_b_value | output | 16 | Second source value (0 when pending) |

## Verification
On every cycle, the assertions check these properties:
- each rename lands in its register on the next edge;
- a matching broadcast clears the tag and loads the value unless a rename takes priority;
- a register whose tag differs from the broadcast tag keeps its state;
- a forwarded source always shows the broadcast value, with ready and a zero tag reported together.

The bench scenarios show what depends on event order. These cases are a write-after-write followed by the stale tag's broadcast, a rename colliding with its own clearing broadcast, and a register that reads and renames itself in one dispatch. A register model also checks long random mixes of renames and broadcasts.

// File: rtl/rat_pkg.sv
package rat_pkg;
  parameter int NUM_ARCH = 8;
  parameter int TAG_BITS = 3;
  parameter int VAL_BITS = 16;
  localparam int IDX_BITS = $clog2(NUM_ARCH);

  typedef logic [IDX_BITS-1:0] arch_idx_t;
  typedef logic [TAG_BITS-1:0] tag_t;
  typedef logic [VAL_BITS-1:0] val_t;

  // a stored tag is matched only by a live broadcast of a nonzero tag
  function automatic logic tag_hit(input tag_t stored, input logic bv, input tag_t bt);
    return bv && (bt != '0) && (stored == bt);
  endfunction

  function automatic logic is_pending(input tag_t t);
    return t != '0;
  endfunction
endpackage

// File: rtl/rat_tag_table.sv
module rat_tag_table
  import rat_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rename_en,
  input  arch_idx_t                rename_reg,
  input  tag_t                     rename_tag,
  input  logic                     bcast_valid,
  input  tag_t                     bcast_tag,
  output tag_t [NUM_ARCH-1:0]      tags,
  output logic [NUM_ARCH-1:0]      bcast_hit
);
  logic [NUM_ARCH-1:0] rename_hit;

  for (genvar i = 0; i < NUM_ARCH; i++) begin : g_entry
    assign rename_hit[i] = rename_en && (rename_reg == arch_idx_t'(i));
    assign bcast_hit[i]  = tag_hit(tags[i], bcast_valid, bcast_tag);

    always_ff @(posedge clk) begin
      if (!rst_n)             tags[i] <= '0;
      else if (rename_hit[i]) tags[i] <= rename_tag;   // rename wins over clear
      else if (bcast_hit[i])  tags[i] <= '0;
    end

    a_r4_rename_lands: assert property (@(posedge clk) disable iff (!rst_n)
      rename_hit[i] |=> tags[i] == $past(rename_tag));
    a_r5_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bcast_hit[i] && !rename_hit[i]) |=> tags[i] == '0);
    a_r6_mismatch_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (!bcast_hit[i] && !rename_hit[i]) |=> $stable(tags[i]));
  end

  a_r4_tag_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    rename_en |-> is_pending(rename_tag));
endmodule

// File: rtl/rat_value_file.sv
module rat_value_file
  import rat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_ARCH-1:0]  wr_mask,
  input  val_t                 wr_data,
  output val_t [NUM_ARCH-1:0]  vals
);
  for (genvar i = 0; i < NUM_ARCH; i++) begin : g_word
    // the value lands whenever the stored tag matched, even if renamed this cycle
    always_ff @(posedge clk) begin
      if (!rst_n)          vals[i] <= '0;
      else if (wr_mask[i]) vals[i] <= wr_data;
    end

    a_r5_value_written: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask[i] |=> vals[i] == $past(wr_data));
    a_r6_value_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mask[i] |=> $stable(vals[i]));
  end
endmodule

// File: rtl/rat_read_port.sv
module rat_read_port
  import rat_pkg::*;
(
  input  arch_idx_t              src_reg,
  input  tag_t [NUM_ARCH-1:0]    tags,
  input  val_t [NUM_ARCH-1:0]    vals,
  input  logic                   bcast_valid,
  input  tag_t                   bcast_tag,
  input  val_t                   bcast_value,
  output logic                   ready,
  output logic                   forwarded,
  output tag_t                   tag_out,
  output val_t                   value_out
);
  tag_t stored;
  assign stored    = tags[src_reg];
  assign forwarded = tag_hit(stored, bcast_valid, bcast_tag);

  always_comb begin
    if (!is_pending(stored)) begin
      ready = 1'b1; tag_out = '0; value_out = vals[src_reg];
    end else if (forwarded) begin
      ready = 1'b1; tag_out = '0; value_out = bcast_value;
    end else begin
      ready = 1'b0; tag_out = stored; value_out = '0;
    end
  end
endmodule

// File: rtl/register_alias_table.sv
module register_alias_table
  import rat_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rename_en,
  input  logic [IDX_BITS-1:0]   rename_reg,
  input  logic [TAG_BITS-1:0]   rename_tag,
  input  logic                  bcast_valid,
  input  logic [TAG_BITS-1:0]   bcast_tag,
  input  logic [VAL_BITS-1:0]   bcast_value,
  input  logic [IDX_BITS-1:0]   src_a_reg,
  input  logic [IDX_BITS-1:0]   src_b_reg,
  output logic                  src_a_ready,
  output logic [TAG_BITS-1:0]   src_a_tag,
  output logic [VAL_BITS-1:0]   src_a_value,
  output logic                  src_b_ready,
  output logic [TAG_BITS-1:0]   src_b_tag,
  output logic [VAL_BITS-1:0]   src_b_value
);
  localparam int NUM_SRC = 2;

  tag_t [NUM_ARCH-1:0] tags;
  val_t [NUM_ARCH-1:0] vals;
  logic [NUM_ARCH-1:0] bcast_hit;

  arch_idx_t  src_reg  [NUM_SRC];
  logic       src_rdy  [NUM_SRC];
  logic       src_fwd  [NUM_SRC];
  tag_t       src_tag  [NUM_SRC];
  val_t       src_val  [NUM_SRC];

  assign src_reg[0] = src_a_reg;
  assign src_reg[1] = src_b_reg;

  rat_tag_table u_tags (
    .clk(clk), .rst_n(rst_n),
    .rename_en(rename_en), .rename_reg(rename_reg), .rename_tag(rename_tag),
    .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
    .tags(tags), .bcast_hit(bcast_hit));

  rat_value_file u_vals (
    .clk(clk), .rst_n(rst_n),
    .wr_mask(bcast_hit), .wr_data(bcast_value), .vals(vals));

  for (genvar p = 0; p < NUM_SRC; p++) begin : g_port
    rat_read_port u_rd (
      .src_reg(src_reg[p]), .tags(tags), .vals(vals),
      .bcast_valid(bcast_valid), .bcast_tag(bcast_tag), .bcast_value(bcast_value),
      .ready(src_rdy[p]), .forwarded(src_fwd[p]),
      .tag_out(src_tag[p]), .value_out(src_val[p]));

    a_r7_forward_value: assert property (@(posedge clk) disable iff (!rst_n)
      src_fwd[p] |-> (src_rdy[p] && src_val[p] == bcast_value));
    a_r3_ready_vs_tag: assert property (@(posedge clk) disable iff (!rst_n)
      src_rdy[p] == (src_tag[p] == '0));
  end

  assign src_a_ready = src_rdy[0];
  assign src_a_tag   = src_tag[0];
  assign src_a_value = src_val[0];
  assign src_b_ready = src_rdy[1];
  assign src_b_tag   = src_tag[1];
  assign src_b_value = src_val[1];
endmodule

// File: tb/register_alias_table_test.sv
module register_alias_table_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rename_en = 1'b0;
  logic [2:0]  rename_reg = '0, rename_tag = '0;
  logic        bcast_valid = 1'b0;
  logic [2:0]  bcast_tag = '0;
  logic [15:0] bcast_value = '0;
  logic [2:0]  src_a_reg = '0, src_b_reg = '0;
  logic        src_a_ready, src_b_ready;
  logic [2:0]  src_a_tag, src_b_tag;
  logic [15:0] src_a_value, src_b_value;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [2:0]  m_tag [8];
  logic [15:0] m_val [8];

  always #5 clk = ~clk;

  register_alias_table uut (.*);

  function automatic logic [19:0] expect_src(input logic [2:0] r);
    logic [2:0] t = m_tag[r];
    if (t == 0) return {1'b1, 3'd0, m_val[r]};
    if (bcast_valid && bcast_tag != 0 && bcast_tag == t) return {1'b1, 3'd0, bcast_value};
    return {1'b0, t, 16'd0};
  endfunction

  function automatic string auto_label(input logic [2:0] r);
    if (m_tag[r] == 0) return "R2";
    if (bcast_valid && bcast_tag == m_tag[r]) return "R7";
    return "R3";
  endfunction

  task automatic check_port(input string lbl, input string pn, input logic [2:0] r,
                            input logic [19:0] act);
    logic [19:0] exp = expect_src(r);
    string l = (lbl == "") ? auto_label(r) : lbl;
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s port %s reg %0d: actual rdy=%0b tag=%0d val=%h expected rdy=%0b tag=%0d val=%h",
               l, pn, r, act[19], act[18:16], act[15:0], exp[19], exp[18:16], exp[15:0]);
    end
  endtask

  task automatic step(input string lbl, input logic ren, input logic [2:0] rr, input logic [2:0] rt,
                      input logic bv, input logic [2:0] bt, input logic [15:0] bval,
                      input logic [2:0] sa, input logic [2:0] sb);
    @(negedge clk);
    rename_en = ren; rename_reg = rr; rename_tag = rt;
    bcast_valid = bv; bcast_tag = bt; bcast_value = bval;
    src_a_reg = sa; src_b_reg = sb;
    #1;
    check_port(lbl, "a", sa, {src_a_ready, src_a_tag, src_a_value});
    check_port(lbl, "b", sb, {src_b_ready, src_b_tag, src_b_value});
    for (int i = 0; i < 8; i++) begin
      logic hit = bv && bt != 0 && m_tag[i] == bt;
      if (hit) m_val[i] = bval;
      if (ren && rr == 3'(i)) m_tag[i] = rt;
      else if (hit) m_tag[i] = 0;
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) begin m_tag[i] = 0; m_val[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int i = 0; i < 8; i += 2) step("R1", 0, 0, 0, 0, 0, 0, 3'(i), 3'(i+1));
    // R10: read old mapping while renaming r1
    step("R10", 1, 3'd1, 3'd2, 0, 0, 0, 3'd1, 3'd1);
    step("R3", 0, 0, 0, 0, 0, 0, 3'd1, 3'd0);
    // R4: write-after-write rename while tag 2 pending
    step("R4", 1, 3'd1, 3'd5, 0, 0, 0, 3'd1, 3'd1);
    step("R4", 0, 0, 0, 0, 0, 0, 3'd1, 3'd1);
    // R6: stale tag 2 broadcast leaves r1 on tag 5
    step("R6", 0, 0, 0, 1, 3'd2, 16'h1111, 3'd1, 3'd1);
    step("R6", 0, 0, 0, 0, 0, 0, 3'd1, 3'd0);
    // R7 then R5
    step("R7", 0, 0, 0, 1, 3'd5, 16'hABCD, 3'd1, 3'd1);
    step("R5", 0, 0, 0, 0, 0, 0, 3'd1, 3'd1);
    // R8: rename and clearing broadcast on r3 together
    step("R3", 1, 3'd3, 3'd4, 0, 0, 0, 3'd3, 3'd3);
    step("R8", 1, 3'd3, 3'd6, 1, 3'd4, 16'h4444, 3'd2, 3'd2);
    step("R8", 0, 0, 0, 0, 0, 0, 3'd3, 3'd3);
    // R9: invalid broadcast of tag 6, then tag 0 broadcast
    step("R9", 0, 0, 0, 0, 3'd6, 16'h9999, 3'd0, 3'd0);
    step("R9", 0, 0, 0, 1, 3'd0, 16'h7777, 3'd3, 3'd0);
    step("R9", 0, 0, 0, 0, 0, 0, 3'd3, 3'd1);
    step("R5", 0, 0, 0, 1, 3'd6, 16'h6666, 3'd3, 3'd3);
    step("R5", 0, 0, 0, 0, 0, 0, 3'd3, 3'd1);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic ren = ($urandom % 3) == 0;
      logic [2:0] rr = 3'($urandom);
      logic [2:0] rt = 3'(1 + $urandom % 7);
      logic bv = ($urandom % 2) == 0;
      logic [2:0] bt = (($urandom % 4) != 0) ? m_tag[$urandom % 8] : 3'($urandom);
      step("", ren, rr, rt, bv, bt, 16'($urandom), 3'($urandom), 3'($urandom));
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule